// File: doc/BRIEF.md
# Per-Slot Virtual Cycle Accountant

This block keeps a virtual clock for each thread slot of a two-wide in-order multithreaded issue stage. A virtual clock measures how much of a slot's single-threaded execution time has elapsed. When lower-priority slots share the issue stage, real cycles stop matching that time. The accountant therefore advances a slot's clock only for cycles the slot would also have spent running alone. It skips cycles in which a higher-priority slot held a functional unit the slot needed.

Every cycle the issue stage reports three things for each slot. The first is the units that the slot's current single-threaded issue group needs. The second is the units it was actually granted. The third is whether the slot is waiting on its own latency, such as a memory access or a branch. A per-slot pending register remembers which units of a partly issued group are still outstanding. A round-start pulse reloads every counter with its quantum. A slot whose counter reaches zero is suspended until the next round through an active-low enable output.

Top module: `vca_accountant`

## Requirements
- R1: A round-start pulse loads each slot's counter with its quantum on the next clock and clears its pending group. A slot loaded with zero is suspended at once.
- R2: An active slot whose outstanding units are all granted in one cycle decrements its counter by exactly one. This holds for each slot independently, so two slots that each need one different unit both decrement in the same cycle.
- R3: A partial grant does not decrement the counter. The ungranted units are held as pending. While units are pending, new request masks are ignored. The counter decrements once, in the cycle the last pending unit is granted.
- R4: A slot that receives none of its outstanding units, because another slot holds them, keeps its count.
- R5: An active slot flagged in latency decrements by one whatever the grants are. Its pending group is kept unchanged.
- R6: An active slot with no request, no pending group and no latency keeps its count.
- R7: A slot whose counter is zero has en_no high. It never decrements, and its pending group is cleared until the next round start. After reset all counters are zero.
- R8: In a round-start cycle the issue information is ignored, and the counter takes exactly the quantum.
- R9: Slots are accounted independently; stimulus to one slot never changes another slot's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| round_start_i | input | 1 | Round boundary pulse, reload counters |
| quantum_i | input | NUM_SLOTS*CNT_W | Per-slot cycle quantum, slot s at bits [s*CNT_W +: CNT_W] |
| req_i | input | NUM_SLOTS*NUM_UNITS | Units the slot's single-threaded issue group needs, bit u is unit u |
| grant_i | input | NUM_SLOTS*NUM_UNITS | Units granted to the slot this cycle |
| lat_i | input | NUM_SLOTS | Slot is stalled on its own latency |
| en_no | output | NUM_SLOTS | Active-low slot enable, high when suspended |
| count_o | output | NUM_SLOTS*CNT_W | Remaining virtual cycles per slot |

## Verification
Assertions check on every cycle the following rules. A counter reloads exactly from the quantum. It steps down by one only on a completed group or a latency cycle, and it holds otherwise. Pending groups only shrink while no latency is present, they are frozen across a latency cycle, and they are cleared once a slot is suspended. Only the bench scenarios can show the rest of the behaviour. That covers the sequence of a group issued over several cycles, with later requests ignored. It also covers a unit taken by another slot without the count advancing, suspension while requests continue, the pending state being discarded at a round boundary, and the independence of slots under random traffic compared cycle by cycle with a behavioural model.

// File: rtl/vca_pkg.sv
package vca_pkg;
  parameter int unsigned VCA_UNITS = 2;
  parameter int unsigned VCA_CNT_W = 8;

  // group finished when nothing outstanding remains after this cycle's grant
  function automatic logic group_done(input logic [VCA_UNITS-1:0] outst,
                                      input logic [VCA_UNITS-1:0] grant);
    return (outst != '0) && ((outst & ~grant) == '0);
  endfunction
endpackage

// File: rtl/vca_group_track.sv
module vca_group_track
  import vca_pkg::*;
#(
  parameter int unsigned NUM_UNITS = VCA_UNITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 round_start_i,
  input  logic                 active_i,
  input  logic [NUM_UNITS-1:0] req_i,
  input  logic [NUM_UNITS-1:0] grant_i,
  input  logic                 lat_i,
  output logic                 adv_o
);
  logic [NUM_UNITS-1:0] pend_q, pend_d, outst, left;

  always_comb begin
    outst = (pend_q != '0) ? pend_q : req_i;
    left  = outst & ~grant_i;
    adv_o = active_i && !round_start_i && (lat_i || ((outst != '0) && (left == '0)));
    if (round_start_i || !active_i) pend_d = '0;
    else if (lat_i)                 pend_d = pend_q;
    else                            pend_d = left;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  // R3: outstanding set of a group never grows without a new group
  p_pend_shrink_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!round_start_i && !lat_i && pend_q != '0) |=> ((pend_q & ~$past(pend_q)) == '0));
  // R5: latency freezes the pending group
  p_lat_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && lat_i && !round_start_i) |=> (pend_q == $past(pend_q)));
  // R7: suspended slot drops its pending group
  p_susp_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i) |=> (pend_q == '0));
endmodule

// File: rtl/vca_quantum_ctr.sv
module vca_quantum_ctr
  import vca_pkg::*;
#(
  parameter int unsigned CNT_W = VCA_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             round_start_i,
  input  logic [CNT_W-1:0] quantum_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (round_start_i) cnt_q <= quantum_i;
    else if (adv_i)         cnt_q <= cnt_q - CNT_W'(1);
  end

  assign count_o  = cnt_q;
  assign active_o = (cnt_q != '0);

  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_start_i |=> (cnt_q == $past(quantum_i)));
  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!round_start_i && adv_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!round_start_i && !adv_i) |=> $stable(cnt_q));
  p_zero_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!round_start_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/vca_accountant.sv
module vca_accountant
  import vca_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NUM_UNITS = VCA_UNITS,
  parameter int unsigned CNT_W     = VCA_CNT_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           round_start_i,
  input  logic [NUM_SLOTS*CNT_W-1:0]     quantum_i,
  input  logic [NUM_SLOTS*NUM_UNITS-1:0] req_i,
  input  logic [NUM_SLOTS*NUM_UNITS-1:0] grant_i,
  input  logic [NUM_SLOTS-1:0]           lat_i,
  output logic [NUM_SLOTS-1:0]           en_no,
  output logic [NUM_SLOTS*CNT_W-1:0]     count_o
);
  logic [NUM_SLOTS-1:0] adv, active;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    vca_group_track #(.NUM_UNITS(NUM_UNITS)) u_grp (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .round_start_i(round_start_i),
      .active_i     (active[s]),
      .req_i        (req_i[s*NUM_UNITS +: NUM_UNITS]),
      .grant_i      (grant_i[s*NUM_UNITS +: NUM_UNITS]),
      .lat_i        (lat_i[s]),
      .adv_o        (adv[s])
    );
    vca_quantum_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .round_start_i(round_start_i),
      .quantum_i    (quantum_i[s*CNT_W +: CNT_W]),
      .adv_i        (adv[s]),
      .count_o      (count_o[s*CNT_W +: CNT_W]),
      .active_o     (active[s])
    );
    assign en_no[s] = !active[s];

    // R7: a suspended slot is never advanced
    p_no_adv_susp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_no[s] |-> !adv[s]);
  end
endmodule

// File: tb/sim_vca_accountant.sv
module sim_vca_accountant;
  localparam int N = 4, U = 2, W = 8;
  logic clk = 0, rst_n = 0, rs = 0;
  logic [N*W-1:0] q = '0;
  logic [N*U-1:0] req = '0, gnt = '0;
  logic [N-1:0] lat = '0, en_n;
  logic [N*W-1:0] cnt;
  int checks = 0, errors = 0;
  int mcnt[N];
  int mpend[N];
  string tag = "R7";

  always #2 clk = ~clk;

  vca_accountant #(.NUM_SLOTS(N), .NUM_UNITS(U), .CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .round_start_i(rs), .quantum_i(q),
    .req_i(req), .grant_i(gnt), .lat_i(lat), .en_no(en_n), .count_o(cnt));

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N; s++) begin mcnt[s] = 0; mpend[s] = 0; end
    end else begin
      for (int s = 0; s < N; s++) begin
        int o, l;
        if (rs) begin mcnt[s] = int'(q[s*W +: W]); mpend[s] = 0; end
        else if (mcnt[s] == 0) mpend[s] = 0;
        else if (lat[s]) mcnt[s] = mcnt[s] - 1;
        else begin
          o = (mpend[s] != 0) ? mpend[s] : int'(req[s*U +: U]);
          l = o & ~int'(gnt[s*U +: U]);
          if (o != 0 && l == 0) mcnt[s] = mcnt[s] - 1;
          mpend[s] = l;
        end
      end
    end
  end

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int c(int s); return int'(cnt[s*W +: W]); endfunction

  task automatic step();
    @(posedge clk); #1;
    for (int s = 0; s < N; s++) begin
      chk(c(s) == mcnt[s], tag, c(s), mcnt[s]);
      chk(en_n[s] == (mcnt[s] == 0), tag, int'(en_n[s]), int'(mcnt[s] == 0));
    end
  endtask

  task automatic idle();
    rs = 0; req = '0; gnt = '0; lat = '0;
  endtask

  task automatic drive(int s, int r, int g, bit l);
    req[s*U +: U] = U'(r); gnt[s*U +: U] = U'(g); lat[s] = l;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    for (int s = 0; s < N; s++) chk(c(s) == 0 && en_n[s], "R7", c(s), 0);
    rst_n = 1;
    // R1 load, slot3 zero quantum suspended
    tag = "R1"; rs = 1; q = {8'd0, 8'd3, 8'd4, 8'd5}; step(); idle();
    chk(c(0) == 5 && c(1) == 4 && c(2) == 3, "R1", c(0), 5);
    chk(en_n == 4'b1000, "R1", int'(en_n), 8);
    // R2 two single-unit slots both advance; R9 idle slot2 untouched
    tag = "R2"; drive(0, 1, 1, 0); drive(1, 2, 2, 0); step(); idle();
    chk(c(0) == 4 && c(1) == 3, "R2", c(1), 3);
    chk(c(2) == 3, "R9", c(2), 3);
    // R3 group spanning two cycles, later request ignored
    tag = "R3"; drive(1, 3, 1, 0); step();
    chk(c(1) == 3, "R3", c(1), 3);
    drive(1, 0, 0, 0); step();
    chk(c(1) == 3, "R3", c(1), 3);
    drive(1, 1, 2, 0); step(); idle();
    chk(c(1) == 2, "R3", c(1), 2);
    // R4 needed unit held by other slot
    tag = "R4"; drive(2, 1, 0, 0); step();
    chk(c(2) == 3, "R4", c(2), 3);
    drive(2, 1, 2, 0); step();
    chk(c(2) == 3, "R4", c(2), 3);
    // R5 latency advances regardless of grants (pending unit 0 from above kept)
    tag = "R5"; drive(2, 0, 3, 1); step(); idle();
    chk(c(2) == 2, "R5", c(2), 2);
    drive(2, 0, 1, 0); step(); idle();
    chk(c(2) == 1, "R5", c(2), 1);
    // R6 nothing requested
    tag = "R6"; step();
    chk(c(0) == 4 && c(1) == 2 && c(2) == 1, "R6", c(1), 2);
    // R5 pending held across latency
    tag = "R5"; drive(1, 3, 2, 0); step();
    chk(c(1) == 2, "R5", c(1), 2);
    drive(1, 0, 0, 1); step();
    chk(c(1) == 1, "R5", c(1), 1);
    drive(1, 0, 1, 0); step(); idle();
    chk(c(1) == 0 && en_n[1], "R5", c(1), 0);
    // R7 suspended slot stays at zero
    tag = "R7"; drive(1, 3, 3, 1); step();
    chk(c(1) == 0 && en_n[1], "R7", c(1), 0);
    idle();
    for (int i = 0; i < 5; i++) begin drive(0, 1, 1, 0); step(); end
    idle();
    chk(c(0) == 0 && en_n[0], "R7", c(0), 0);
    // R8 round start overrides issue info
    tag = "R8"; rs = 1; q = {8'd2, 8'd2, 8'd2, 8'd2};
    drive(0, 1, 1, 0); drive(2, 0, 0, 1); step(); idle();
    chk(c(0) == 2 && c(2) == 2 && en_n == 4'b0000, "R8", c(0), 2);
    // R1/R3 round start discards a pending group
    tag = "R3"; drive(1, 3, 1, 0); step(); idle();
    rs = 1; step(); idle();
    drive(1, 1, 1, 0); step(); idle();
    chk(c(1) == 1, "R1", c(1), 1);
    // R9 random traffic against reference
    tag = "R9";
    for (int i = 0; i < 2000; i++) begin
      rs = ($urandom_range(0, 29) == 0);
      for (int s = 0; s < N; s++) q[s*W +: W] = W'($urandom_range(0, 12));
      req = (N*U)'($urandom); gnt = (N*U)'($urandom);
      lat = N'($urandom) & N'($urandom);
      step();
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule